// File: doc/BRIEF.md
# Buck Controller Supervisory Sequencer

This block is the digital supervisor of a synchronous step-down controller. It receives already-digitized comparator results (supply-rail lockout thresholds, the shared compensation/disable pin thresholds, the die-temperature trip and release points, the output over-voltage trip and release points) and a per-cycle over-current flag. It also receives a strobe that marks the start of every switching period. From these it decides which operating mode the converter is in and how the two gate drivers may be used.

The mode is reported on a three-bit code. The gate drivers get one of three commands: both off, low side forced on with the high side held off, or normal PWM. A reference ramp is also produced. It rises in equal steps, one step per switching period, during soft start and then sits at full scale. Repeated over-current in normal operation triggers a timed hiccup, and the block then retries with a fresh soft start.

Top module: `buck_seq`

## Requirements
- R1: After reset, and whenever the supply-low flag has been seen, the mode code is 1 (lockout), the gate command is 0 (both off) and the ramp is 0. A supply-low pulse is reflected two clock edges later from any mode. When supply-low and supply-high arrive together, supply-low wins.
- R2: A pin-low pulse puts the block in mode 0 (shutdown) with gate command 0 and ramp 0 two edges later. It stays there until a pin-high pulse arrives. If the supply is good, that pulse starts soft start two edges later.
- R3: With the supply good and the pin enabled, the block enters mode 2 (soft start) with the ramp at 0. Each cycle strobe raises the ramp by STEP = floor((2^RAMP_W-1)/SS_CYCLES). The strobe numbered SS_CYCLES sets the ramp to full scale (all ones), and the next edge enters mode 3 (normal).
- R4: A cycle strobe with the over-current flag set, in soft start or normal mode, makes the gate command 1 (low side forced) from that strobe until the next strobe. In soft start such strobes are never counted toward a fault.
- R5: In normal mode, OC_LIMIT consecutive strobes with over-current enter mode 4 (fault) one edge after the last of them. A strobe without over-current restarts the count. A fault can only be entered from normal mode.
- R6: In fault mode the gate command is 1 and the ramp is 0, and over-current flags have no effect. After HICCUP_PERIODS*SS_CYCLES strobes counted in fault mode, the next edge re-enters soft start.
- R7: An over-voltage trip pulse makes the gate command 1 one edge later. The command returns to 2 one edge after an over-voltage release pulse. The mode code does not change.
- R8: An over-temperature trip enters mode 5 (thermal) two edges later, with gate command 1 and the ramp at full scale. A temperature release returns to mode 3 two edges later.
- R9: Priority from highest to lowest is lockout, shutdown, thermal, fault, over-voltage, then soft-start/normal behaviour. A shutdown overrides thermal mode, and a thermal trip overrides an active fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_low_i | input | 1 | Control pin fell below the disable threshold |
| en_high_i | input | 1 | Control pin rose above the enable threshold |
| vl_low_i | input | 1 | Internal supply fell below the lockout entry threshold |
| vl_high_i | input | 1 | Internal supply rose above the lockout exit threshold |
| ot_hot_i | input | 1 | Die temperature above the trip point |
| ot_cool_i | input | 1 | Die temperature below the release point |
| ov_trip_i | input | 1 | Output above the over-voltage trip level |
| ov_clear_i | input | 1 | Output below trip level minus hysteresis |
| oc_flag_i | input | 1 | Over-current seen in the current switching cycle |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching cycle |
| gate_mode_o | output | 2 | 0 both off, 1 low side forced, 2 normal PWM |
| ref_ramp_o | output | RAMP_W | Soft-start reference ramp value |
| mode_o | output | 3 | 0 shutdown, 1 lockout, 2 soft start, 3 normal, 4 fault, 5 thermal |

## Verification
The hardest situation to reach is the exit edge of the hiccup window. Getting there requires a completed soft start, then an unbroken run of over-current strobes in normal mode, then exactly one hundred and twelve further strobes inside the fault mode. The stimulus drives that sequence with a strobe task and sets the over-current flag on every fault-mode strobe, so that ignoring the flag is exercised as well. It samples just before and just after the final strobe. Near-miss runs (six over-current strobes then a clean one, and over-current throughout soft start) show that the count restarts and that soft start never counts.

// File: rtl/buck_seq_pkg.sv
`timescale 1ns/1ps
package buck_seq_pkg;

    typedef enum logic [2:0] {
        M_SHUT  = 3'd0,
        M_UVLO  = 3'd1,
        M_SOFT  = 3'd2,
        M_RUN   = 3'd3,
        M_FAULT = 3'd4,
        M_THERM = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        G_OFF = 2'd0,
        G_LOW = 2'd1,
        G_PWM = 2'd2
    } gate_e;

    typedef struct packed {
        mode_e mode;
        logic  oc_cyc;
    } ctl_t;

endpackage

// File: rtl/bsq_hyst_flag.sv
`timescale 1ns/1ps
module bsq_hyst_flag #(
    parameter bit CLR_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (CLR_WINS) begin
            if (set_i) flag_d = 1'b1;
            if (clr_i) flag_d = 1'b0;
        end else begin
            if (clr_i) flag_d = 1'b0;
            if (set_i) flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/bsq_run_counter.sv
`timescale 1ns/1ps
module bsq_run_counter #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic strobe_i,
    input  logic hit_i,
    output logic reached_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active_i) begin
            cnt_d = '0;
        end else if (strobe_i) begin
            if (!hit_i)           cnt_d = '0;
            else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached_o = (cnt_q == LIM);

endmodule

// File: rtl/bsq_ss_ramp.sv
`timescale 1ns/1ps
module bsq_ss_ramp #(
    parameter int RAMP_W    = 10,
    parameter int SS_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              strobe_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              done_o
);

    localparam int CW     = $clog2(SS_CYCLES + 1);
    localparam int FULL_I = (1 << RAMP_W) - 1;
    localparam int STEP_I = FULL_I / SS_CYCLES;
    localparam logic [CW-1:0] LAST = CW'(SS_CYCLES);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [RAMP_W-1:0] ramp;
    } ss_t;

    ss_t ss_d, ss_q;

    always_comb begin
        ss_d = ss_q;
        if (!run_i) begin
            ss_d.cnt  = '0;
            ss_d.ramp = '0;
        end else if (strobe_i && (ss_q.cnt != LAST)) begin
            ss_d.cnt = ss_q.cnt + 1'b1;
            if (ss_q.cnt == LAST - 1'b1) ss_d.ramp = {RAMP_W{1'b1}};
            else                         ss_d.ramp = ss_q.ramp + RAMP_W'(STEP_I);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_q <= '0;
        else        ss_q <= ss_d;
    end

    assign ramp_o = ss_q.ramp;
    assign done_o = (ss_q.cnt == LAST);

endmodule

// File: rtl/buck_seq.sv
`timescale 1ns/1ps
module buck_seq
    import buck_seq_pkg::*;
#(
    parameter int RAMP_W         = 10,
    parameter int SS_CYCLES      = 16,
    parameter int OC_LIMIT       = 7,
    parameter int HICCUP_PERIODS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_low_i,
    input  logic              en_high_i,
    input  logic              vl_low_i,
    input  logic              vl_high_i,
    input  logic              ot_hot_i,
    input  logic              ot_cool_i,
    input  logic              ov_trip_i,
    input  logic              ov_clear_i,
    input  logic              oc_flag_i,
    input  logic              cyc_start_i,
    output logic [1:0]        gate_mode_o,
    output logic [RAMP_W-1:0] ref_ramp_o,
    output logic [2:0]        mode_o
);

    localparam int HICCUP_STROBES = HICCUP_PERIODS * SS_CYCLES;
    localparam int NFLAG = 4;
    localparam int F_SUP = 0;
    localparam int F_ENA = 1;
    localparam int F_HOT = 2;
    localparam int F_OVP = 3;
    // supply and enable latches favour the clearing side; hot and ovp favour tripping
    localparam logic [NFLAG-1:0] CLR_WINS = 4'b0011;

    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

    assign flag_set = {ov_trip_i,  ot_hot_i,  en_high_i, vl_high_i};
    assign flag_clr = {ov_clear_i, ot_cool_i, sd_low_i,  vl_low_i};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        bsq_hyst_flag #(.CLR_WINS(CLR_WINS[g])) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_q[g])
        );
    end

    ctl_t ctl_d, ctl_q;

    logic              ss_done, oc_reached, hiccup_done;
    logic [RAMP_W-1:0] ss_ramp;
    logic              in_soft, in_run, in_fault;

    assign in_soft  = (ctl_q.mode == M_SOFT);
    assign in_run   = (ctl_q.mode == M_RUN);
    assign in_fault = (ctl_q.mode == M_FAULT);

    bsq_ss_ramp #(.RAMP_W(RAMP_W), .SS_CYCLES(SS_CYCLES)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_soft),
        .strobe_i (cyc_start_i),
        .ramp_o   (ss_ramp),
        .done_o   (ss_done)
    );

    bsq_run_counter #(.LIMIT(OC_LIMIT)) u_oc_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (in_run),
        .strobe_i  (cyc_start_i),
        .hit_i     (oc_flag_i),
        .reached_o (oc_reached)
    );

    bsq_run_counter #(.LIMIT(HICCUP_STROBES)) u_hiccup (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (in_fault),
        .strobe_i  (cyc_start_i),
        .hit_i     (1'b1),
        .reached_o (hiccup_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        // mode, highest priority first
        if (!flag_q[F_SUP]) begin
            ctl_d.mode = M_UVLO;
        end else if (!flag_q[F_ENA]) begin
            ctl_d.mode = M_SHUT;
        end else if (flag_q[F_HOT]) begin
            ctl_d.mode = M_THERM;
        end else begin
            unique case (ctl_q.mode)
                M_UVLO, M_SHUT: ctl_d.mode = M_SOFT;
                M_SOFT:         if (ss_done)     ctl_d.mode = M_RUN;
                M_RUN:          if (oc_reached)  ctl_d.mode = M_FAULT;
                M_FAULT:        if (hiccup_done) ctl_d.mode = M_SOFT;
                M_THERM:        ctl_d.mode = M_RUN;
                default:        ctl_d.mode = M_UVLO;
            endcase
        end
        // per-cycle over-current hold, live only while switching
        if (!(in_soft || in_run)) ctl_d.oc_cyc = 1'b0;
        else if (cyc_start_i)     ctl_d.oc_cyc = oc_flag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode   <= M_UVLO;
            ctl_q.oc_cyc <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    gate_e             gate_sel;
    logic [RAMP_W-1:0] ramp_sel;
    logic              force_low;

    assign force_low = flag_q[F_OVP] || ctl_q.oc_cyc;

    always_comb begin
        gate_sel = G_OFF;
        ramp_sel = '0;
        unique case (ctl_q.mode)
            M_SOFT: begin
                gate_sel = force_low ? G_LOW : G_PWM;
                ramp_sel = ss_ramp;
            end
            M_RUN: begin
                gate_sel = force_low ? G_LOW : G_PWM;
                ramp_sel = {RAMP_W{1'b1}};
            end
            M_FAULT: begin
                gate_sel = G_LOW;
                ramp_sel = '0;
            end
            M_THERM: begin
                gate_sel = G_LOW;
                ramp_sel = {RAMP_W{1'b1}};
            end
            default: begin
                gate_sel = G_OFF;
                ramp_sel = '0;
            end
        endcase
    end

    assign gate_mode_o = gate_sel;
    assign ref_ramp_o  = ramp_sel;
    assign mode_o      = ctl_q.mode;

endmodule

// File: rtl/buck_seq_chk.sv
`timescale 1ns/1ps
module buck_seq_chk
    import buck_seq_pkg::*;
#(
    parameter int RAMP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_low_i,
    input logic              vl_low_i,
    input logic              ov_trip_i,
    input logic              oc_flag_i,
    input logic              cyc_start_i,
    input logic [1:0]        gate_mode_o,
    input logic [RAMP_W-1:0] ref_ramp_o,
    input logic [2:0]        mode_o
);

    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vl_low_i |=> ##1 (mode_o == M_UVLO && gate_mode_o == G_OFF));

    p_shutdown_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sd_low_i |=> ##1 (gate_mode_o == G_OFF));

    p_ramp_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SOFT && $past(mode_o) == M_SOFT) |-> (ref_ramp_o >= $past(ref_ramp_o)));

    p_fault_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == M_FAULT) |-> ($past(mode_o) == M_RUN));

    p_fault_ignores_oc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_FAULT && cyc_start_i && oc_flag_i) |=> (mode_o != M_RUN));

    p_ov_blocks_pwm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ov_trip_i |=> (gate_mode_o != G_PWM));

endmodule

bind buck_seq buck_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_low_i    (sd_low_i),
    .vl_low_i    (vl_low_i),
    .ov_trip_i   (ov_trip_i),
    .oc_flag_i   (oc_flag_i),
    .cyc_start_i (cyc_start_i),
    .gate_mode_o (gate_mode_o),
    .ref_ramp_o  (ref_ramp_o),
    .mode_o      (mode_o)
);

// File: tb/buck_seq_bench.sv
`timescale 1ns/1ps
module buck_seq_bench;

    localparam int RW     = 10;
    localparam int SS     = 16;
    localparam int OCL    = 7;
    localparam int HIC    = 7;
    localparam int STEP   = ((1 << RW) - 1) / SS;
    localparam logic [RW-1:0] FULL = {RW{1'b1}};

    localparam logic [2:0] MS_SHUT = 3'd0, MS_UVLO = 3'd1, MS_SOFT = 3'd2,
                           MS_RUN  = 3'd3, MS_FAULT = 3'd4, MS_THERM = 3'd5;
    localparam logic [1:0] GT_OFF = 2'd0, GT_LOW = 2'd1, GT_PWM = 2'd2;

    localparam int P_SDL = 0, P_ENH = 1, P_VLL = 2, P_VLH = 3, P_HOT = 4,
                   P_COOL = 5, P_OVT = 6, P_OVC = 7, P_VLBOTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_low = 0, en_high = 0, vl_low = 0, vl_high = 0;
    logic ot_hot = 0, ot_cool = 0, ov_trip = 0, ov_clear = 0;
    logic oc_flag = 0, cyc_start = 0;
    logic [1:0]    gate_mode;
    logic [RW-1:0] ref_ramp;
    logic [2:0]    mode;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    buck_seq #(.RAMP_W(RW), .SS_CYCLES(SS), .OC_LIMIT(OCL), .HICCUP_PERIODS(HIC)) u_buck_seq (
        .clk(clk), .rst_n(rst_n),
        .sd_low_i(sd_low), .en_high_i(en_high), .vl_low_i(vl_low), .vl_high_i(vl_high),
        .ot_hot_i(ot_hot), .ot_cool_i(ot_cool), .ov_trip_i(ov_trip), .ov_clear_i(ov_clear),
        .oc_flag_i(oc_flag), .cyc_start_i(cyc_start),
        .gate_mode_o(gate_mode), .ref_ramp_o(ref_ramp), .mode_o(mode)
    );

    typedef struct {
        logic [2:0]    mode;
        logic [1:0]    gate;
        logic [RW-1:0] ramp;
        string         tag;
    } exp_t;

    exp_t sbq[$];

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [2:0] m, input logic [1:0] g,
                              input logic [RW-1:0] r, input string tag);
        exp_t e;
        e.mode = m; e.gate = g; e.ramp = r; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic strobe(input logic oc);
        cyc_start = 1'b1;
        oc_flag   = oc;
        @(negedge clk);
        cyc_start = 1'b0;
        oc_flag   = 1'b0;
    endtask

    task automatic pulse(input int sel);
        case (sel)
            P_SDL:    sd_low   = 1'b1;
            P_ENH:    en_high  = 1'b1;
            P_VLL:    vl_low   = 1'b1;
            P_VLH:    vl_high  = 1'b1;
            P_HOT:    ot_hot   = 1'b1;
            P_COOL:   ot_cool  = 1'b1;
            P_OVT:    ov_trip  = 1'b1;
            P_OVC:    ov_clear = 1'b1;
            default: begin vl_low = 1'b1; vl_high = 1'b1; end
        endcase
        @(negedge clk);
        sd_low = 0; en_high = 0; vl_low = 0; vl_high = 0;
        ot_hot = 0; ot_cool = 0; ov_trip = 0; ov_clear = 0;
    endtask

    // monitor: compares queued expectations one time unit after they are pushed
    initial begin
        forever begin
            wait (sbq.size() > 0);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                compared++;
                if (mode !== e.mode || gate_mode !== e.gate || ref_ramp !== e.ramp) begin
                    mismatched++;
                    $display("FAIL %s: mode/gate/ramp got %0d/%0d/%0d expected %0d/%0d/%0d",
                             e.tag, mode, gate_mode, ref_ramp, e.mode, e.gate, e.ramp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cyc(2);
        expect_out(MS_UVLO, GT_OFF, '0, "R1 state during reset");
        cyc(1);
        rst_n = 1'b1;
        cyc(2);
        expect_out(MS_UVLO, GT_OFF, '0, "R1 after reset");

        pulse(P_ENH); cyc(2);
        expect_out(MS_UVLO, GT_OFF, '0, "R1 lockout outranks enable");

        pulse(P_VLH); cyc(1);
        expect_out(MS_SOFT, GT_PWM, '0, "R3 soft start entered");

        strobe(1'b0);
        expect_out(MS_SOFT, GT_PWM, RW'(STEP), "R3 first ramp step");
        strobe(1'b1);
        expect_out(MS_SOFT, GT_LOW, RW'(2 * STEP), "R4 over-current cycle in soft start");
        repeat (8) strobe(1'b1);
        expect_out(MS_SOFT, GT_LOW, RW'(10 * STEP), "R4 soft start over-current not counted");
        repeat (5) strobe(1'b0);
        expect_out(MS_SOFT, GT_PWM, RW'(15 * STEP), "R3 ramp before last step");
        strobe(1'b0);
        expect_out(MS_SOFT, GT_PWM, FULL, "R3 ramp at full scale");
        cyc(1);
        expect_out(MS_RUN, GT_PWM, FULL, "R3 normal after soft start");

        repeat (OCL - 1) strobe(1'b1);
        strobe(1'b0);
        expect_out(MS_RUN, GT_PWM, FULL, "R5 clean strobe restarts count");
        repeat (OCL - 1) strobe(1'b1);
        expect_out(MS_RUN, GT_LOW, FULL, "R4 over-current cycle in normal");
        strobe(1'b1);
        expect_out(MS_RUN, GT_LOW, FULL, "R5 fault not before following edge");
        cyc(1);
        expect_out(MS_FAULT, GT_LOW, '0, "R5 fault entered");

        repeat (HIC * SS - 1) strobe(1'b1);
        expect_out(MS_FAULT, GT_LOW, '0, "R6 hiccup holds, over-current ignored");
        strobe(1'b1);
        expect_out(MS_FAULT, GT_LOW, '0, "R6 hiccup last strobe");
        cyc(1);
        expect_out(MS_SOFT, GT_PWM, '0, "R6 retry soft start");

        repeat (SS) strobe(1'b0);
        cyc(1);
        expect_out(MS_RUN, GT_PWM, FULL, "R3 normal after retry");

        pulse(P_OVT);
        expect_out(MS_RUN, GT_LOW, FULL, "R7 over-voltage forces low side");
        cyc(3);
        expect_out(MS_RUN, GT_LOW, FULL, "R7 over-voltage held");
        pulse(P_OVC);
        expect_out(MS_RUN, GT_PWM, FULL, "R7 over-voltage released");

        pulse(P_HOT); cyc(1);
        expect_out(MS_THERM, GT_LOW, FULL, "R8 thermal entered");
        pulse(P_SDL); cyc(1);
        expect_out(MS_SHUT, GT_OFF, '0, "R9 shutdown outranks thermal");
        cyc(3);
        expect_out(MS_SHUT, GT_OFF, '0, "R2 shutdown held");
        pulse(P_COOL); cyc(1);
        expect_out(MS_SHUT, GT_OFF, '0, "R2 shutdown not left by cooling");
        pulse(P_ENH); cyc(1);
        expect_out(MS_SOFT, GT_PWM, '0, "R2 enable restarts soft start");

        repeat (SS) strobe(1'b0);
        cyc(1);
        expect_out(MS_RUN, GT_PWM, FULL, "R3 normal again");
        repeat (OCL) strobe(1'b1);
        cyc(1);
        expect_out(MS_FAULT, GT_LOW, '0, "R5 second fault");
        pulse(P_HOT); cyc(1);
        expect_out(MS_THERM, GT_LOW, FULL, "R9 thermal outranks fault");
        pulse(P_COOL); cyc(1);
        expect_out(MS_RUN, GT_PWM, FULL, "R8 cooling resumes normal");

        pulse(P_VLL); cyc(1);
        expect_out(MS_UVLO, GT_OFF, '0, "R1 lockout from normal");
        pulse(P_VLBOTH); cyc(2);
        expect_out(MS_UVLO, GT_OFF, '0, "R1 supply-low wins over supply-high");
        pulse(P_VLH); cyc(1);
        expect_out(MS_SOFT, GT_PWM, '0, "R3 soft start after lockout");

        cyc(2);
        wait (sbq.size() == 0);
        cyc(1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule